// File: doc/BRIEF.md
# Sliding-Window Register Operand Mapper

This block turns the logical register operands of an instruction into physical indices into one shared register file. Procedures see a private window of that file. A window-set command fixes how many entries the current procedure may use. A call slides the window base forward to an offset chosen by the caller, so the callee's first register sits on the caller's argument slots. A return brings back the caller's view exactly as it was before the call.

A second, movable pointer overlays the current window. Operands of a base-relative class index from that pointer, which gives array-style access to a run of entries. Global registers do not take part in windowing and always map to a fixed block of physical entries placed after the windowed ones.

Translation is combinational and is done on two read ports and one write port. Each port gets a physical index and a flag that marks an operand outside the current window. Saving windows to memory and the register storage itself lie outside this block.

Top module: `win_reg_map`

## Requirements
- R1: After reset the window base, window size, pointer offset and saved-state depth are all zero, the error output is low, and so every windowed operand is flagged out of window.
- R2: An operand of class 2 (global) with index g below 32 maps to physical entry 128 + g and is never flagged. This holds whatever the window state is.
- R3: Command 0 (window-set) sets the window size to its argument, counted in entries. A class-0 (windowed) operand with index i then maps to base + i and is flagged when i is not below the size.
- R4: Command 1 (call) with argument k moves the base to base + 2k. The new size is the old size minus 2k, or zero when 2k exceeds the old size. The pointer offset becomes zero.
- R5: Command 2 (return) restores the base, size and pointer offset that were in force before the matching call.
- R6: Command 3 (pointer-set) with argument k sets the pointer offset to 2k entries. A class-1 (base-relative) operand b[i] then maps to base + offset + i.
- R7: A base-relative operand is flagged when i is 8 or more, or when offset + i is not below the window size.
- R8: A call while 16 states are saved, or while STACK_DEPTH states are saved, leaves all state unchanged. The error output is high for exactly the one cycle after the rejected command and is low after any accepted command.
- R9: A return while no state is saved leaves all state unchanged and raises the error output for one cycle.
- R10: All windowed and base-relative address arithmetic wraps modulo 128.
- R11: Class 3 is reserved. It is always flagged and yields physical index 0.
- R12: When the caller sets its pointer to the argument offset of a call, the caller's b[0] and the callee's r0 resolve to the same physical entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 window-set, 1 call, 2 return, 3 pointer-set |
| cmd_arg | input | 7 | Window size in entries, or offset in quadwords |
| rd0_cls | input | 2 | Read port 0 operand class: 0 windowed, 1 base-relative, 2 global |
| rd0_idx | input | 7 | Read port 0 logical index |
| rd0_phys | output | 8 | Read port 0 physical index |
| rd0_oow | output | 1 | Read port 0 out-of-window flag |
| rd1_cls | input | 2 | Read port 1 operand class |
| rd1_idx | input | 7 | Read port 1 logical index |
| rd1_phys | output | 8 | Read port 1 physical index |
| rd1_oow | output | 1 | Read port 1 out-of-window flag |
| wr_cls | input | 2 | Write port operand class |
| wr_idx | input | 7 | Write port logical index |
| wr_phys | output | 8 | Write port physical index |
| wr_oow | output | 1 | Write port out-of-window flag |
| err | output | 1 | One-cycle pulse after a rejected call or return |

## Verification
The bench builds the block with STACK_DEPTH set to 4. Four nested calls are then enough to fill the saved-state stack, so the rejected-call case and the full unwind down to the rejected return on an empty stack take only a few cycles. The file keeps its default 128 windowed entries. A call with a large argument therefore pushes the base near the top, and the modulo wrap of windowed and base-relative operands can be reached directly.

// File: rtl/win_reg_map.sv
module win_reg_map #(
  parameter int PHYS        = 128,
  parameter int GLOBALS     = 32,
  parameter int BASE_REGS   = 8,
  parameter int STACK_DEPTH = 16,
  localparam int PW = $clog2(PHYS),
  localparam int OW = $clog2(PHYS + GLOBALS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [PW-1:0] cmd_arg,
  input  logic [1:0]    rd0_cls,
  input  logic [PW-1:0] rd0_idx,
  output logic [OW-1:0] rd0_phys,
  output logic          rd0_oow,
  input  logic [1:0]    rd1_cls,
  input  logic [PW-1:0] rd1_idx,
  output logic [OW-1:0] rd1_phys,
  output logic          rd1_oow,
  input  logic [1:0]    wr_cls,
  input  logic [PW-1:0] wr_idx,
  output logic [OW-1:0] wr_phys,
  output logic          wr_oow,
  output logic          err
);
  localparam int SW = $clog2(STACK_DEPTH + 1);
  localparam int AW = $clog2(STACK_DEPTH);
  localparam logic [1:0] OP_SETWD = 2'd0, OP_CALL = 2'd1, OP_RET = 2'd2, OP_SETBN = 2'd3;
  localparam logic [1:0] CLS_WIN = 2'd0, CLS_BASE = 2'd1, CLS_GLB = 2'd2;

  logic [PW-1:0] base_q, size_q, bpo_q;
  logic [SW-1:0] depth_q;
  logic          err_q;
  logic [PW-1:0] stk_base [STACK_DEPTH];
  logic [PW-1:0] stk_size [STACK_DEPTH];
  logic [PW-1:0] stk_bpo  [STACK_DEPTH];

  wire [PW:0]    twice   = {cmd_arg, 1'b0};
  wire           is_call = cmd_valid && cmd_op == OP_CALL;
  wire           is_ret  = cmd_valid && cmd_op == OP_RET;
  wire           full    = depth_q == SW'(STACK_DEPTH);
  wire           empty   = depth_q == '0;
  wire [PW:0]    remain  = {1'b0, size_q} - twice;
  wire [PW-1:0]  callee_size = (twice > {1'b0, size_q}) ? '0 : remain[PW-1:0];
  wire [AW-1:0]  push_at = AW'(depth_q);
  wire [AW-1:0]  pop_at  = AW'(depth_q - 1'b1);

  assign err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= '0;
      bpo_q   <= '0;
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (is_call && full) || (is_ret && empty);
      if (cmd_valid) begin
        case (cmd_op)
          OP_SETWD: size_q <= cmd_arg;
          OP_SETBN: bpo_q  <= twice[PW-1:0];
          OP_CALL: if (!full) begin
            base_q  <= base_q + twice[PW-1:0];
            size_q  <= callee_size;
            bpo_q   <= '0;
            depth_q <= depth_q + 1'b1;
          end
          default: if (!empty) begin
            base_q  <= stk_base[pop_at];
            size_q  <= stk_size[pop_at];
            bpo_q   <= stk_bpo[pop_at];
            depth_q <= depth_q - 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (is_call && !full) begin
      stk_base[push_at] <= base_q;
      stk_size[push_at] <= size_q;
      stk_bpo[push_at]  <= bpo_q;
    end
  end

  function automatic logic [OW:0] xlate(input logic [1:0] cls, input logic [PW-1:0] idx,
                                        input logic [PW-1:0] b, input logic [PW-1:0] sz,
                                        input logic [PW-1:0] bp);
    logic [PW:0]   rel;
    logic [PW-1:0] sum;
    logic [OW-1:0] p;
    logic          o;
    rel = {1'b0, bp} + {1'b0, idx};
    p   = '0;
    o   = 1'b1;
    case (cls)
      CLS_WIN: begin
        sum = b + idx;
        p   = OW'(sum);
        o   = idx >= sz;
      end
      CLS_BASE: begin
        sum = b + bp + idx;
        p   = OW'(sum);
        o   = (idx >= PW'(BASE_REGS)) || (rel >= {1'b0, sz});
      end
      CLS_GLB: begin
        o = idx >= PW'(GLOBALS);
        p = o ? '0 : OW'(PHYS) + OW'(idx);
      end
      default: ;
    endcase
    return {o, p};
  endfunction

  assign {rd0_oow, rd0_phys} = xlate(rd0_cls, rd0_idx, base_q, size_q, bpo_q);
  assign {rd1_oow, rd1_phys} = xlate(rd1_cls, rd1_idx, base_q, size_q, bpo_q);
  assign {wr_oow,  wr_phys}  = xlate(wr_cls,  wr_idx,  base_q, size_q, bpo_q);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= SW'(STACK_DEPTH)); // R8
  AST_SETWD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_SETWD |=> size_q == $past(cmd_arg)); // R3
  AST_CALL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    is_call && !full |=> base_q == $past(base_q) + {$past(cmd_arg[PW-2:0]), 1'b0} && bpo_q == '0); // R4
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    is_call && full |=> err && $stable(base_q) && $stable(size_q) && $stable(depth_q)); // R8
  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret && empty |=> err && $stable(base_q) && $stable(size_q) && $stable(bpo_q)); // R9
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret && !empty |=> !err && depth_q == $past(depth_q) - 1'b1); // R5
  AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_cls == CLS_GLB && rd0_idx < PW'(GLOBALS) |-> !rd0_oow && rd0_phys == OW'(PHYS) + OW'(rd0_idx)); // R2
  AST_RESERVED_CLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cls == 2'd3 |-> wr_oow && wr_phys == '0); // R11
endmodule

// File: tb/sim_win_reg_map.sv
module sim_win_reg_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [6:0] cmd_arg = '0;
  logic [1:0] rd0_cls = '0, rd1_cls = '0, wr_cls = '0;
  logic [6:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [7:0] rd0_phys, rd1_phys, wr_phys;
  logic rd0_oow, rd1_oow, wr_oow, err;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_reg_map #(.STACK_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rd0_cls(rd0_cls), .rd0_idx(rd0_idx), .rd0_phys(rd0_phys), .rd0_oow(rd0_oow),
    .rd1_cls(rd1_cls), .rd1_idx(rd1_idx), .rd1_phys(rd1_phys), .rd1_oow(rd1_oow),
    .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_phys(wr_phys), .wr_oow(wr_oow), .err(err));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_arg = 7'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input int cls, input int idx, input int exp_phys, input int exp_oow);
    rd0_cls = 2'(cls); rd0_idx = 7'(idx);
    rd1_cls = 2'(cls); rd1_idx = 7'(idx);
    wr_cls  = 2'(cls); wr_idx  = 7'(idx);
    #1;
    chk({tag, " rd0 oow"}, int'(rd0_oow), exp_oow);
    chk({tag, " rd1 oow"}, int'(rd1_oow), exp_oow);
    chk({tag, " wr oow"}, int'(wr_oow), exp_oow);
    if (exp_oow == 0 || cls == 3) begin
      chk({tag, " rd0 phys"}, int'(rd0_phys), exp_phys);
      chk({tag, " rd1 phys"}, int'(rd1_phys), exp_phys);
      chk({tag, " wr phys"}, int'(wr_phys), exp_phys);
    end
  endtask

  task automatic t_reset;
    chk("R1 err after reset", int'(err), 0);
    probe("R1 r0 unwindowed", 0, 0, 0, 1);
    probe("R2 g5", 2, 5, 133, 0);
    probe("R2 g31", 2, 31, 159, 0);
    probe("R11 reserved class", 3, 4, 0, 1);
  endtask

  task automatic t_setwd;
    cmd(0, 20);
    chk("R8 err low after accepted", int'(err), 0);
    probe("R3 r0", 0, 0, 0, 0);
    probe("R3 r19", 0, 19, 19, 0);
    probe("R3 r20 edge", 0, 20, 0, 1);
  endtask

  task automatic t_call_ret;
    cmd(3, 4);
    probe("R6 b0", 1, 0, 8, 0);
    probe("R6 b3", 1, 3, 11, 0);
    probe("R12 caller b0", 1, 0, 8, 0);
    cmd(1, 4);
    probe("R12 callee r0", 0, 0, 8, 0);
    probe("R4 callee r11", 0, 11, 19, 0);
    probe("R4 callee r12 edge", 0, 12, 0, 1);
    probe("R4 callee b0 offset cleared", 1, 0, 8, 0);
    probe("R2 global in callee", 2, 0, 128, 0);
    cmd(2, 0);
    chk("R5 err after return", int'(err), 0);
    probe("R5 caller r19", 0, 19, 19, 0);
    probe("R5 caller r20", 0, 20, 0, 1);
    probe("R5 caller b1", 1, 1, 9, 0);
  endtask

  task automatic t_base_oow;
    cmd(3, 8);
    probe("R7 b3 last inside", 1, 3, 19, 0);
    probe("R7 b4 past size", 1, 4, 0, 1);
    cmd(3, 0);
    probe("R7 b8 index too big", 1, 8, 0, 1);
    probe("R7 b7 inside", 1, 7, 7, 0);
    cmd(3, 8);
  endtask

  task automatic t_wrap;
    cmd(0, 100);
    cmd(1, 60);
    probe("R4 oversized offset size zero", 0, 0, 0, 1);
    cmd(0, 30);
    probe("R10 r0 high", 0, 0, 120, 0);
    probe("R10 r10 wraps", 0, 10, 2, 0);
    cmd(3, 5);
    probe("R10 b7 wraps", 1, 7, 9, 0);
    probe("R2 g7 after wrap", 2, 7, 135, 0);
    cmd(2, 0);
    probe("R5 b0 restored", 1, 0, 16, 0);
    probe("R5 r99 restored", 0, 99, 99, 0);
  endtask

  task automatic t_full_empty;
    cmd(0, 50);
    cmd(3, 0);
    for (int i = 0; i < 4; i++) cmd(1, 1);
    probe("R4 nested r0", 0, 0, 8, 0);
    cmd(1, 1);
    chk("R8 err on full call", int'(err), 1);
    probe("R8 r0 unchanged", 0, 0, 8, 0);
    probe("R8 r41 unchanged", 0, 41, 49, 0);
    probe("R8 r42 unchanged", 0, 42, 0, 1);
    @(negedge clk);
    chk("R8 err one cycle", int'(err), 0);
    for (int i = 0; i < 4; i++) cmd(2, 0);
    chk("R5 err after unwind", int'(err), 0);
    probe("R5 r49 unwound", 0, 49, 49, 0);
    cmd(2, 0);
    chk("R9 err on empty return", int'(err), 1);
    probe("R9 r49 unchanged", 0, 49, 49, 0);
    probe("R9 r50 unchanged", 0, 50, 0, 1);
    cmd(0, 50);
    chk("R9 err cleared", int'(err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setwd();
    t_call_ret();
    t_base_oow();
    t_wrap();
    t_full_empty();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule